// File: doc/BRIEF.md
# Dual-Channel Packed-Register PWM Generator

This peripheral drives two independent pulse-width-modulated outputs. Each channel has one 32-bit control word on a small memory-mapped bus. The word holds a run bit, an 8-bit clock divider and an 8-bit inverted duty code. The divider turns the input clock into a step clock. Every output period is 256 steps long. The duty code sets how many of those steps the output stays high.

Software writes a channel's word in a single cycle and reads it back one cycle after a read strobe. New divider and duty settings take effect only when the current period ends, so a waveform never carries a truncated or stretched period. Setting the run bit starts the waveform at step zero, high side first.

Top module: `dual_pwm_gen`

## Requirements
- R1: There are two channels. Channel n's control word sits at byte address 4*n, which needs addr[1:0] = 0. A write is taken on the clock edge where wr_en is high.
- R2: Bit 31 (run), bits 15:8 (divider) and bits 7:0 (duty code) read back exactly as written. Bits 30:16 always read as zero. Read data appears on rdata after the clock edge on which rd_en is high.
- R3: A read of any other address (an unaligned address, 8 or 12) returns zero. A write to such an address changes no channel.
- R4: While rst_n is low at a clock edge, both control words clear to zero and both outputs go low.
- R5: While a channel's run bit is 0, its output stays low and its counters stay idle, even when the divider and duty fields hold nonzero values.
- R6: A divider value N from 1 to 255 advances the step counter once every N input clocks. A value of 0 acts as N = 256. One output period lasts 256*N input clocks.
- R7: A duty code D from 1 to 255 keeps the output high for steps 0 to 255-D, which is (256-D) steps of each period, and low for the remaining steps.
- R8: A duty code of 0 keeps the output low for the whole period.
- R9: Divider and duty values written while a channel runs take effect only at the next period start. The period in progress finishes with the old values.
- R10: When the run bit changes from 0 to 1, the period restarts at step 0. With a nonzero duty code the output is high from the second rising edge after the write edge.
- R11: The two channels run independently. Writes and waveforms on one channel do not change the other channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 4 | Byte address of the bus access |
| wr_en | input | 1 | Write strobe, single cycle |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| pwm_out | output | 2 | PWM outputs, bit n is channel n |

## Verification
The hardest case to set up is a duty change that lands in the middle of a running period. A design that latches too early and one that latches correctly show the same high-time total over a whole period. The bench therefore restarts a channel with divider 1, so its step number equals the number of clocks since the restart. It then writes a shorter duty at step 100, where the old code still drives high and the new code would drive low. The output is sampled at step 101 of that period and at two known steps of the next period. Every other duty and divider combination is measured by counting high samples over a window of one whole period. That count does not depend on phase.

// File: rtl/pwm_gen_pkg.sv
// Package pwm_gen_pkg
// Shared field layout and configuration type for the dual PWM generator.
// Assumes a 32-bit control word with run at bit 31, divider at 15:8 and
// duty code at 7:0; bits between them are reserved and read as zero.
package pwm_gen_pkg;

    localparam int WORD_W    = 32;
    localparam int FIELD_W   = 8;
    localparam int RUN_BIT   = WORD_W - 1;
    localparam int DIV_LSB   = FIELD_W;
    localparam int DUTY_LSB  = 0;
    localparam int RSVD_W    = RUN_BIT - (DIV_LSB + FIELD_W);

    typedef struct packed {
        logic               run;
        logic [FIELD_W-1:0] divider;
        logic [FIELD_W-1:0] duty;
    } chan_cfg_t;

    // Turn a bus word into the stored configuration (reserved bits dropped).
    function automatic chan_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        chan_cfg_t c;
        c.run     = w[RUN_BIT];
        c.divider = w[DIV_LSB +: FIELD_W];
        c.duty    = w[DUTY_LSB +: FIELD_W];
        return c;
    endfunction

    // Rebuild the bus word from the stored configuration.
    function automatic logic [WORD_W-1:0] cfg_to_word(input chan_cfg_t c);
        return {c.run, {RSVD_W{1'b0}}, c.divider, c.duty};
    endfunction

endpackage

// File: rtl/pwm_reg_bank.sv
// Module pwm_reg_bank
// Holds one configuration word per channel and serves the bus. Writes take
// effect on the strobe edge. Reads are registered. Any address that is not
// word aligned or lies past the last channel reads as zero and ignores writes.
// Assumes NUM_CH <= 2**(ADDR_W-2).
module pwm_reg_bank
    import pwm_gen_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic [WORD_W-1:0]       wdata,
    input  logic                    rd_en,
    output logic [WORD_W-1:0]       rdata,
    output chan_cfg_t [NUM_CH-1:0]  cfg
);

    localparam int IDX_W = ADDR_W - 2;

    logic [NUM_CH-1:0] hit;
    logic              any_hit;
    logic [WORD_W-1:0] rd_word;

    // Decode which channel word the address selects.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            hit[i] = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] == IDX_W'(i));
        end
        any_hit = |hit;
    end

    // Pick the read word of the selected channel, zero when none is selected.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i]) rd_word = cfg_to_word(cfg[i]);
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= any_hit ? rd_word : '0;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_word
        // Per-channel configuration storage.
        always_ff @(posedge clk) begin
            if (!rst_n)                cfg[g] <= '0;
            else if (wr_en && hit[g])  cfg[g] <= word_to_cfg(wdata);
        end

        assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && hit[g]) |=> (cfg[g].run == $past(wdata[RUN_BIT])) &&
                                  (cfg[g].divider == $past(wdata[DIV_LSB +: FIELD_W])) &&
                                  (cfg[g].duty == $past(wdata[DUTY_LSB +: FIELD_W])));

        assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && hit[g]) |=> $stable(cfg[g]));
    end

    assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !any_hit) |=> (rdata == '0));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata[RUN_BIT-1:DIV_LSB+FIELD_W] == '0));

endmodule

// File: rtl/pwm_channel.sv
// Module pwm_channel
// One PWM generator. A prescaler divides the clock by the active divider
// (0 counts as 256) into step ticks. A step counter spans one 256-step
// period. The output is high while step <= ~duty, and never when duty is 0.
// Divider and duty are copied into working registers only at a period
// start or when the run bit rises. Assumes cfg comes straight from registers.
module pwm_channel
    import pwm_gen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg,
    output logic      pwm_o
);

    localparam logic [FIELD_W-1:0] STEP_LAST = '1;

    logic               running;
    logic [FIELD_W-1:0] div_cnt;
    logic [FIELD_W-1:0] step;
    logic [FIELD_W-1:0] act_div;
    logic [FIELD_W-1:0] act_duty;
    logic               tick;
    logic               wrap;

    // Step tick when the prescaler reaches divider-1 (0 wraps to 255, giving 256).
    always_comb begin
        tick = (div_cnt == act_div - 1'b1);
        wrap = tick && (step == STEP_LAST);
    end

    // Prescaler, step counter and period-boundary latch of new settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            div_cnt  <= '0;
            step     <= '0;
            act_div  <= '0;
            act_duty <= '0;
        end else if (!cfg.run) begin
            running  <= 1'b0;
            div_cnt  <= '0;
            step     <= '0;
        end else if (!running) begin
            running  <= 1'b1;
            div_cnt  <= '0;
            step     <= '0;
            act_div  <= cfg.divider;
            act_duty <= cfg.duty;
        end else if (tick) begin
            div_cnt <= '0;
            step    <= step + 1'b1;
            if (wrap) begin
                act_div  <= cfg.divider;
                act_duty <= cfg.duty;
            end
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Output compare: high for steps 0 .. 255-duty of each period.
    always_comb begin
        pwm_o = running && (act_duty != '0) && (step <= ~act_duty);
    end

    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.run |=> (!pwm_o && (step == '0) && (div_cnt == '0)));

    assert_start_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(running) && (cfg.duty != '0)) |-> pwm_o);

    assert_hold_mid_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg.run && !wrap) |=> ($stable(act_div) && $stable(act_duty)));

    assert_step_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg.run && tick && !wrap) |=> (step == $past(step) + 1'b1));

    assert_div_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (div_cnt <= act_div - 1'b1));

endmodule

// File: rtl/dual_pwm_gen.sv
// Module dual_pwm_gen
// Top of the dual PWM generator: a register bank on the bus and one
// pwm_channel per configuration word. Assumes a single clock domain and a
// synchronous active-low reset.
module dual_pwm_gen
    import pwm_gen_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_cfg_t [NUM_CH-1:0] cfg;

    pwm_reg_bank #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .wdata (wdata),
        .rd_en (rd_en),
        .rdata (rdata),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm_channel i_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (cfg[g]),
            .pwm_o (pwm_out[g])
        );
    end

    assert_reset_low_R4: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0));

endmodule

// File: tb/test_dual_pwm_gen.sv
// Bench for dual_pwm_gen: a table of divider/duty vectors with expected
// high-sample counts over one period, then directed corner-case tests.
module test_dual_pwm_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 150000;
    localparam int NVEC = 8;
    localparam logic [31:0] RUN = 32'h8000_0000;

    // Entry: {divider[31:24], duty[23:16], expected high samples in one period[15:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd1, 8'd1,   16'd255},
        {8'd1, 8'd128, 16'd128},
        {8'd2, 8'd128, 16'd256},
        {8'd3, 8'd255, 16'd3},
        {8'd1, 8'd0,   16'd0},
        {8'd4, 8'd64,  16'd768},
        {8'd2, 8'd200, 16'd112},
        {8'd1, 8'd255, 16'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dual_pwm_gen i_dual_pwm_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rd_en   (rd_en),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic count_high(input int n, output int h0, output int h1);
        h0 = 0; h1 = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[0]) h0++;
            if (pwm_out[1]) h1++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int h0, h1;
        logic [7:0] dv, du;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: reset state
        check("R4 outputs after reset", {30'd0, pwm_out}, 32'd0);
        bus_read(4'd0, rd); check("R4 ch0 word after reset", rd, 32'd0);
        bus_read(4'd4, rd); check("R4 ch1 word after reset", rd, 32'd0);

        // R2 and R1: readback with reserved bits masked
        bus_write(4'd0, 32'hFFFF_1234);
        bus_read(4'd0, rd); check("R2 ch0 readback masks 30:16", rd, 32'h8000_1234);
        bus_write(4'd4, 32'h0000_5A3C);
        bus_read(4'd4, rd); check("R1 ch1 at offset 4 readback", rd, 32'h0000_5A3C);
        bus_write(4'd0, 32'd0);

        // R3: other addresses read zero and ignore writes
        bus_write(4'd8, 32'hFFFF_FFFF);
        bus_write(4'd2, 32'hFFFF_FFFF);
        bus_write(4'd12, 32'hFFFF_FFFF);
        bus_read(4'd0, rd);  check("R3 ch0 untouched by stray writes", rd, 32'd0);
        bus_read(4'd4, rd);  check("R3 ch1 untouched by stray writes", rd, 32'h0000_5A3C);
        bus_read(4'd8, rd);  check("R3 read of addr 8", rd, 32'd0);
        bus_read(4'd1, rd);  check("R3 read of unaligned addr 1", rd, 32'd0);
        bus_read(4'd12, rd); check("R3 read of addr 12", rd, 32'd0);

        // R11 reference: channel 1 runs divider 1, duty 128 throughout
        bus_write(4'd4, RUN | 32'h0000_0180);

        // Table walk: R6, R7, R8 on channel 0, R11 on channel 1
        for (int v = 0; v < NVEC; v++) begin
            dv = VEC[v][31:24];
            du = VEC[v][23:16];
            bus_write(4'd0, 32'd0);
            bus_write(4'd0, RUN | {16'd0, dv, du});
            repeat (4) @(negedge clk);
            count_high(256 * int'(dv), h0, h1);
            if (du == 8'd0)
                check("R8 zero duty high count", h0, 32'(VEC[v][15:0]));
            else if (dv != 8'd1)
                check("R6 divided period high count", h0, 32'(VEC[v][15:0]));
            else
                check("R7 duty high count", h0, 32'(VEC[v][15:0]));
            check("R11 ch1 unaffected high count", h1, 32'(128 * int'(dv)));
        end

        // R6: divider 0 acts as 256, period 65536 clocks, duty 192 -> 64 high steps
        bus_write(4'd0, 32'd0);
        bus_write(4'd0, RUN | 32'h0000_00C0);
        repeat (4) @(negedge clk);
        count_high(65536, h0, h1);
        check("R6 divider 0 means 256", h0, 32'd16384);

        // R5: run bit clear with nonzero fields keeps the output low
        bus_write(4'd0, 32'h0000_0180);
        bus_read(4'd0, rd); check("R2 readback with run clear", rd, 32'h0000_0180);
        count_high(512, h0, h1);
        check("R5 disabled output low", h0, 32'd0);

        // R10: restart from step 0, output high on the second edge after the write
        bus_write(4'd0, 32'd0);
        bus_write(4'd0, RUN | 32'h0000_0180);
        check("R10 low before restart edge", {31'd0, pwm_out[0]}, 32'd0);
        @(negedge clk);
        check("R10 high at step 0", {31'd0, pwm_out[0]}, 32'd1);

        // R9: at step 99 write duty 200 (high steps 0..55); old 128 holds to step 127
        repeat (99) @(negedge clk);
        bus_write(4'd0, RUN | 32'h0000_01C8);
        check("R9 old duty holds mid-period (step 101)", {31'd0, pwm_out[0]}, 32'd1);
        repeat (195) @(negedge clk);
        check("R9 new duty high at next period step 40", {31'd0, pwm_out[0]}, 32'd1);
        repeat (20) @(negedge clk);
        check("R9 new duty low at next period step 60", {31'd0, pwm_out[0]}, 32'd0);

        // R4: reset while both channels run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R4 outputs low during reset", {30'd0, pwm_out}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(4'd0, rd); check("R4 ch0 cleared by reset", rd, 32'd0);
        bus_read(4'd4, rd); check("R4 ch1 cleared by reset", rd, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule